// File: doc/BRIEF.md
# I2C Controller Event and Status Flag Register

This block holds the 32-bit read-only status word of an I2C controller. The bus protocol engine reports what it sees as single-cycle pulses: a start or stop condition, an address hit with the captured address code and R/W bit, a refused acknowledge, arbitration loss, a bus error, an overrun, a packet-check error, a reload request, transfer completion and a bus timeout. The register turns those pulses into flags that stay set. Software clears most flags by writing ones to a separate clear strobe. Three low bits mirror the data-path levels (transmit empty, receive data available, transmit request). The bus-busy bit follows start and stop. The address code and direction fields change only when an address hit occurs.

Each flag is ANDed with its bit of an interrupt mask, and the results are ORed into one active-high interrupt line. That path is combinational. An alert flag for the SMBus host role captures falling edges of the alert pin, after the pin passes a two-flop synchronizer. The alert flag and the timeout flag can be removed at build time. When the peripheral enable is low, every flag and field is forced to its idle value. All ports are plain control and status pins, because no data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `i2c_evt_status`

## Requirements
- R1: After reset, `stat_q` reads 0x0000_0001 and `irq` is low while `irq_mask` is zero.
- R2: Bits 31:24 and bit 14 of `stat_q` always read 0.
- R3: On an `ev_match` pulse with the peripheral enabled, bits 23:17 take `match_code` and bit 16 takes `match_read` (0 means a write, so the slave receives; 1 means a read, so the slave transmits). The code field can carry a 10-bit header followed by two address bits. Bit 3 sets on the same edge. Bits 23:16 hold their value in every cycle without `ev_match`.
- R4: Bit 15 (busy) sets on `ev_start` and clears on `ev_stop`. If both arrive in the same cycle, busy ends up set.
- R5: Each sticky flag sets on its event pulse and clears when `clr_wr` is high with a 1 in the matching bit of `clr_mask`. The mapping is: bit 11 `ev_pec_err`, bit 10 `ev_overrun`, bit 9 `ev_arb_lost`, bit 8 `ev_bus_err`, bit 7 `ev_reload`, bit 6 `ev_done`, bit 5 `ev_stop`, bit 4 `ev_nack`, bit 3 `ev_match`. A clear write changes neither busy nor bits 2:0.
- R6: When an event pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R7: Bit 13 (alert) sets on a falling edge of `alert_pin`, three clock edges after the pin falls, but only while `host_mode_en` and `alert_en` are both high. An edge seen while either enable is low is discarded. Writing 1 to clear-mask bit 13 clears the flag.
- R8: Bit 12 (timeout) sets on `ev_timeout` and clears on a write of 1 to clear-mask bit 12.
- R9: While `periph_en` is low, bits 23:3 read 0 one edge later, bits 2:0 read 3'b001, and all event inputs and level inputs are ignored.
- R10: While enabled, bits 2:0 take {`tx_req`, `rx_avail`, `tx_empty`} one edge after those inputs are presented.
- R11: `irq` is the combinational OR of `stat_q[15:0] & irq_mask`.
- R12: With `HAS_SMBUS` = 0, bits 13 and 12 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; low forces idle values |
| host_mode_en | input | 1 | SMBus host role enable |
| alert_en | input | 1 | Alert capture enable |
| alert_pin | input | 1 | Raw alert pin, idle high |
| ev_start | input | 1 | Start condition pulse |
| ev_stop | input | 1 | Stop condition pulse |
| ev_match | input | 1 | Address hit pulse |
| match_code | input | 7 | Address code captured with the hit |
| match_read | input | 1 | R/W bit captured with the hit |
| ev_nack | input | 1 | Acknowledge refused pulse |
| ev_done | input | 1 | Transfer complete pulse |
| ev_reload | input | 1 | Reload request pulse |
| ev_bus_err | input | 1 | Misplaced start/stop pulse |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_overrun | input | 1 | Overrun or underrun pulse |
| ev_pec_err | input | 1 | Packet check mismatch pulse |
| ev_timeout | input | 1 | Timeout or clock-low limit pulse |
| tx_empty | input | 1 | Transmit data register empty level |
| rx_avail | input | 1 | Receive data available level |
| tx_req | input | 1 | Transmit data request level |
| clr_wr | input | 1 | Clear-register write strobe |
| clr_mask | input | 11 | Write-one-to-clear bits for flags 13:3 |
| irq_mask | input | 16 | Interrupt enable per flag bit 15:0 |
| stat_q | output | 32 | Status word |
| irq | output | 1 | Combined interrupt, active high |

## Verification
Two collisions are provoked on purpose. In the first, one cycle carries both an event pulse and a clear write that target the same sticky flag, and the flag is judged at the next falling clock edge, where it must still read 1. In the second, a start and a stop arrive together, so busy must end up set while the stop-seen flag also latches. Both collisions sit as rows in the vector table next to rows that exercise each effect alone, so a swapped priority changes the compared word.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W      = 32;
  localparam int CODE_W      = 7;
  localparam int IRQ_W       = 16;
  localparam int BIT_TX_EMPTY = 0;
  localparam int BIT_LVL_TOP  = 2;
  localparam int BIT_STICKY_LO = 3;
  localparam int BIT_STICKY_HI = 11;
  localparam int STICKY_N     = BIT_STICKY_HI - BIT_STICKY_LO + 1;
  localparam int BIT_TIMEOUT  = 12;
  localparam int BIT_ALERT    = 13;
  localparam int BIT_BUSY     = 15;
  localparam int BIT_DIR      = 16;
  localparam int CODE_LSB     = 17;
  localparam int CODE_MSB     = CODE_LSB + CODE_W - 1;
  localparam logic [2:0] LVL_IDLE = 3'b001;
endpackage

// File: rtl/stat_flag_bank.sv
module stat_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (!en)    q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (en && set[i]) |=> q[i]); // R6
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (en && clr[i] && !set[i]) |=> !q[i]); // R5
  end
endmodule

// File: rtl/stat_alert_edge.sv
module stat_alert_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic arm,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign fall = arm & s3 & ~s2;

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R7
endmodule

// File: rtl/stat_irq_or.sv
module stat_irq_or #(
  parameter int W = 16
) (
  input  logic [W-1:0] flags,
  input  logic [W-1:0] mask,
  output logic         irq
);
  assign irq = |(flags & mask);
endmodule

// File: rtl/i2c_evt_status.sv
module i2c_evt_status
  import i2c_stat_pkg::*;
#(
  parameter bit HAS_SMBUS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              periph_en,
  input  logic              host_mode_en,
  input  logic              alert_en,
  input  logic              alert_pin,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_match,
  input  logic [CODE_W-1:0] match_code,
  input  logic              match_read,
  input  logic              ev_nack,
  input  logic              ev_done,
  input  logic              ev_reload,
  input  logic              ev_bus_err,
  input  logic              ev_arb_lost,
  input  logic              ev_overrun,
  input  logic              ev_pec_err,
  input  logic              ev_timeout,
  input  logic              tx_empty,
  input  logic              rx_avail,
  input  logic              tx_req,
  input  logic              clr_wr,
  input  logic [13:3]       clr_mask,
  input  logic [IRQ_W-1:0]  irq_mask,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq
);
  logic [STICKY_N-1:0] sticky_set, sticky_clr, sticky_q;
  logic [1:0]          smb_q;
  logic                busy_q;
  logic [CODE_W:0]     hit_q;
  logic [2:0]          lvl_q;

  assign sticky_set = {ev_pec_err, ev_overrun, ev_arb_lost, ev_bus_err,
                       ev_reload, ev_done, ev_stop, ev_nack, ev_match};
  assign sticky_clr = clr_wr ? clr_mask[BIT_STICKY_HI:BIT_STICKY_LO] : '0;

  stat_flag_bank #(.N(STICKY_N)) u_sticky (
    .clk(clk), .rst_n(rst_n), .en(periph_en),
    .set(sticky_set), .clr(sticky_clr), .q(sticky_q)
  );

  if (HAS_SMBUS) begin : g_smb
    logic alert_fall;
    logic [1:0] smb_set, smb_clr;

    stat_alert_edge u_alert (
      .clk(clk), .rst_n(rst_n), .pin(alert_pin),
      .arm(periph_en & host_mode_en & alert_en), .fall(alert_fall)
    );

    assign smb_set = {alert_fall, ev_timeout};
    assign smb_clr = clr_wr ? clr_mask[BIT_ALERT:BIT_TIMEOUT] : 2'b00;

    stat_flag_bank #(.N(2)) u_smb (
      .clk(clk), .rst_n(rst_n), .en(periph_en),
      .set(smb_set), .clr(smb_clr), .q(smb_q)
    );
  end else begin : g_no_smb
    logic unused_smb;
    assign unused_smb = ^{clr_mask[BIT_ALERT:BIT_TIMEOUT], ev_timeout,
                          alert_pin, host_mode_en, alert_en};
    assign smb_q = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_q <= 1'b0;
    else if (!periph_en) busy_q <= 1'b0;
    else if (ev_start)  busy_q <= 1'b1;
    else if (ev_stop)   busy_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hit_q <= '0;
    else if (!periph_en) hit_q <= '0;
    else if (ev_match)   hit_q <= {match_code, match_read};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lvl_q <= LVL_IDLE;
    else if (!periph_en) lvl_q <= LVL_IDLE;
    else                 lvl_q <= {tx_req, rx_avail, tx_empty};
  end

  always_comb begin
    stat_q = '0;
    stat_q[BIT_LVL_TOP:BIT_TX_EMPTY]   = lvl_q;
    stat_q[BIT_STICKY_HI:BIT_STICKY_LO] = sticky_q;
    stat_q[BIT_ALERT:BIT_TIMEOUT]      = smb_q;
    stat_q[BIT_BUSY]                   = busy_q;
    stat_q[CODE_MSB:BIT_DIR]           = hit_q;
  end

  stat_irq_or #(.W(IRQ_W)) u_irq (
    .flags(stat_q[IRQ_W-1:0]), .mask(irq_mask), .irq(irq)
  );

  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_en && ev_start) |=> stat_q[BIT_BUSY]); // R4
  AST_BUSY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_en && ev_stop && !ev_start) |=> !stat_q[BIT_BUSY]); // R4
  AST_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_en && !ev_match) |=> $stable(stat_q[CODE_MSB:BIT_DIR])); // R3
  AST_HIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_en && ev_match) |=>
      (stat_q[CODE_MSB:BIT_DIR] == $past({match_code, match_read}))); // R3
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_en |=> (stat_q[CODE_MSB:BIT_STICKY_LO] == '0 &&
                    stat_q[BIT_LVL_TOP:BIT_TX_EMPTY] == LVL_IDLE)); // R9
endmodule

// File: tb/i2c_evt_status_test.sv
module i2c_evt_status_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic periph_en = 0, host_mode_en = 0, alert_en = 0, alert_pin = 1;
  logic ev_start = 0, ev_stop = 0, ev_match = 0, match_read = 0;
  logic [6:0] match_code = '0;
  logic ev_nack = 0, ev_done = 0, ev_reload = 0, ev_bus_err = 0;
  logic ev_arb_lost = 0, ev_overrun = 0, ev_pec_err = 0, ev_timeout = 0;
  logic tx_empty = 1, rx_avail = 0, tx_req = 0, clr_wr = 0;
  logic [13:3] clr_mask = '0;
  logic [15:0] irq_mask = '0;
  logic [31:0] stat_q, stat_ns;
  logic irq, irq_ns;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_evt_status uut (.*);

  i2c_evt_status #(.HAS_SMBUS(1'b0)) uut_ns (
    .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .host_mode_en(host_mode_en),
    .alert_en(alert_en), .alert_pin(alert_pin), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_match(ev_match), .match_code(match_code), .match_read(match_read),
    .ev_nack(ev_nack), .ev_done(ev_done), .ev_reload(ev_reload), .ev_bus_err(ev_bus_err),
    .ev_arb_lost(ev_arb_lost), .ev_overrun(ev_overrun), .ev_pec_err(ev_pec_err),
    .ev_timeout(ev_timeout), .tx_empty(tx_empty), .rx_avail(rx_avail), .tx_req(tx_req),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .irq_mask(irq_mask),
    .stat_q(stat_ns), .irq(irq_ns)
  );

  // event word: bit14 start, bit5 stop, bit3 match, other bits at their flag position
  // entry = {events, clear word, expected stat_q[15:0]}
  localparam int NV = 15;
  localparam logic [47:0] VEC [NV] = '{
    {16'h4000, 16'h0000, 16'h8001},  // R4 start
    {16'h0010, 16'h0000, 16'h8011},  // R5 nack
    {16'h0400, 16'h0000, 16'h8411},  // R5 overrun
    {16'h0000, 16'h0010, 16'h8401},  // R5 clear nack
    {16'h0020, 16'h0000, 16'h0421},  // R4 stop clears busy, R5 stop flag
    {16'h4020, 16'h0000, 16'h8421},  // R4 start and stop together
    {16'h0200, 16'h0200, 16'h8621},  // R6 set beats clear
    {16'h0000, 16'hFFFF, 16'h8001},  // R5 clear all, busy kept
    {16'h1000, 16'h0000, 16'h9001},  // R8 timeout
    {16'h09C0, 16'h0000, 16'h99C1},  // R5 four events at once
    {16'h0000, 16'h1040, 16'h8981},  // R8 R5 clear timeout and done
    {16'h0008, 16'h0000, 16'h8989},  // R3 address hit flag
    {16'h0000, 16'hFFFF, 16'h8001},  // R5 clear all
    {16'h0020, 16'h0000, 16'h0021},  // R4 stop
    {16'h0000, 16'h0020, 16'h0001}   // R5 clear stop flag
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] ev, input logic [15:0] cw);
    ev_start = ev[14]; ev_stop = ev[5]; ev_match = ev[3]; ev_nack = ev[4];
    ev_done = ev[6]; ev_reload = ev[7]; ev_bus_err = ev[8]; ev_arb_lost = ev[9];
    ev_overrun = ev[10]; ev_pec_err = ev[11]; ev_timeout = ev[12];
    clr_wr = |cw; clr_mask = cw[13:3];
  endtask

  task automatic step(input logic [15:0] ev, input logic [15:0] cw);
    drive(ev, cw);
    @(posedge clk);
    @(negedge clk);
    drive('0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset word", stat_q, 32'h0000_0001);
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    periph_en = 1'b1;
    match_code = 7'h2A; match_read = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][47:32], VEC[i][31:16]);
      chk($sformatf("R4 R5 R6 R8 vector %0d", i), {16'h0, stat_q[15:0]}, {16'h0, VEC[i][15:0]});
    end

    // R3 capture and hold
    match_code = 7'h1E; match_read = 1'b0;
    step(16'h0008, '0);
    chk("R3 write hit", {24'h0, stat_q[23:16]}, 32'h3C);
    match_code = 7'h55; match_read = 1'b1;
    step(16'h0010, '0);
    chk("R3 hold without hit", {24'h0, stat_q[23:16]}, 32'h3C);
    match_code = 7'h7B; match_read = 1'b1;
    step(16'h0008, '0);
    chk("R3 ten-bit header read hit", {24'h0, stat_q[23:16]}, 32'hF7);

    // R2 reserved bits with everything set
    step(16'h5FF8, '0);
    chk("R2 reserved zero", {stat_q[31:24], 23'd0, stat_q[14]}, 32'd0);

    // R10 levels
    tx_empty = 0; rx_avail = 1; tx_req = 1;
    @(posedge clk); @(negedge clk);
    chk("R10 levels", {29'd0, stat_q[2:0]}, 32'd6);
    tx_empty = 1; rx_avail = 0; tx_req = 0;
    step('0, 16'hFFFF);
    chk("R10 levels restored", {29'd0, stat_q[2:0]}, 32'd1);

    // R11 interrupt combine
    irq_mask = 16'h0010;
    step(16'h0010, '0);
    chk("R11 irq masked flag", {31'd0, irq}, 32'd1);
    irq_mask = 16'h0000; #1;
    chk("R11 irq mask off", {31'd0, irq}, 32'd0);
    irq_mask = 16'h0001; #1;
    chk("R11 irq on tx empty", {31'd0, irq}, 32'd1);
    irq_mask = '0;
    step('0, 16'hFFFF);

    // R7 alert latency
    host_mode_en = 1; alert_en = 1;
    alert_pin = 0;
    @(posedge clk); @(negedge clk);
    chk("R7 alert after 1 edge", {31'd0, stat_q[13]}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R7 alert after 2 edges", {31'd0, stat_q[13]}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R7 alert after 3 edges", {31'd0, stat_q[13]}, 32'd1);
    alert_pin = 1;
    step('0, 16'h2000);
    chk("R7 alert cleared", {31'd0, stat_q[13]}, 32'd0);
    repeat (3) @(negedge clk);
    alert_en = 0; alert_pin = 0;
    repeat (5) @(negedge clk);
    chk("R7 alert disabled", {31'd0, stat_q[13]}, 32'd0);
    alert_en = 1;
    repeat (4) @(negedge clk);
    chk("R7 stale edge discarded", {31'd0, stat_q[13]}, 32'd0);
    alert_pin = 1;
    repeat (3) @(negedge clk);
    alert_pin = 0;
    repeat (3) @(negedge clk);

    // R12 build without SMBus
    step(16'h1000, '0);
    chk("R12 main build has both", {30'd0, stat_q[13:12]}, 32'd3);
    chk("R12 no-smbus build zero", {30'd0, stat_ns[13:12]}, 32'd0);
    alert_pin = 1;

    // R9 disable
    step(16'h4018, '0);
    periph_en = 0;
    @(posedge clk); @(negedge clk);
    chk("R9 disable clears", stat_q, 32'h0000_0001);
    tx_empty = 0; rx_avail = 1;
    step(16'h5FF8, '0);
    chk("R9 events ignored while off", stat_q, 32'h0000_0001);
    tx_empty = 1; rx_avail = 0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule